// File: doc/BRIEF.md
# Steppable Time-of-Day Counter

This block keeps a running time of day as a seconds count and a nanoseconds count. On every clock the nanoseconds count moves forward by a fixed amount. When it passes the end of a second it folds back and adds one to the seconds count. Software corrects the time by adding an offset to it. The offset is split over three write registers: a nanoseconds offset, the low 32 bits of a seconds offset, and the remaining upper seconds bits.

The two seconds registers only hold their values until they are used. The time changes only when software writes the nanoseconds offset register. That single write adds all three offsets to the running time in the same clock edge. The same path sets the first time after power-up and also applies periodic corrections to a running clock.

A backward step is a seconds offset in two's complement, since seconds arithmetic wraps at the seconds width. The nanoseconds offset must be below the wrap value, so it always moves time forward within a second.

Top module: `rtc_step_counter`

## Requirements
- R1: While the synchronous active-high `rst` is high, `tod_sec`, `tod_ns` and all three offset registers are zero after the next clock edge.
- R2: On a clock edge with no offset applied and no wrap, `tod_ns` grows by exactly `NS_INC` and `tod_sec` is unchanged.
- R3: When `tod_ns + NS_INC` reaches `NS_WRAP`, the new `tod_ns` is the sum minus `NS_WRAP` and `tod_sec` grows by one. `tod_sec` wraps modulo 2^`SEC_W`, and `tod_ns` stays below `NS_WRAP` at all times.
- R4: A write to address 1 stores the seconds offset low bits (`wr_data[31:0]`). A write to address 2 stores the upper seconds offset bits (`wr_data[SEC_W-33:0]`). Neither write changes `tod_sec` or `tod_ns`.
- R5: A write to address 0 applies the offsets at the same clock edge. The result is `tod_ns + NS_INC + wr_data[29:0]`, reduced modulo `NS_WRAP`, with each wrap carried into seconds. The stored seconds offset, plus that carry, is added to `tod_sec`. Normal advance is not lost in that cycle.
- R6: An all-ones seconds offset steps `tod_sec` back by one, because the addition is modulo 2^`SEC_W`.
- R7: Reading addresses 0, 1 and 2 on `rd_addr` returns the last value written there, and reserved bits read as zero. For address 0, bits 31:30 are reserved. For address 2, bits 31:`SEC_W-32` are reserved.
- R8: Writes to address 3 change no register and no time value. Reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 ns offset and apply, 1 seconds low, 2 seconds high |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, combinational readback |
| rd_data | output | 32 | Readback of the selected offset register |
| tod_sec | output | SEC_W | Current seconds |
| tod_ns | output | $clog2(NS_WRAP) | Current nanoseconds |

## Verification
The bench builds the counter with `NS_WRAP` = 1000, `NS_INC` = 7 and `SEC_W` = 40. With these values the nanoseconds field wraps about every 143 cycles, so many second carries happen in a short run. The increment does not divide the wrap value, so wrap remainders differ from one second to the next. A 40-bit seconds width leaves only 8 writable bits in the upper offset register, which tests the reserved readback bits. It also puts a seconds rollover within reach of a single step that sets the seconds to all ones.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_W    = 32;
    localparam int OFS_NS_W = 30;

    typedef enum logic [1:0] {
        ADDR_NS_OFS  = 2'd0,
        ADDR_SEC_LO  = 2'd1,
        ADDR_SEC_HI  = 2'd2,
        ADDR_SPARE   = 2'd3
    } rtc_addr_e;

    // Apply command handed from the register file to the counter.
    typedef struct packed {
        logic                apply;
        logic [OFS_NS_W-1:0] ns;
    } rtc_cmd_t;

    // Nanosecond sum after reduction: remainder plus wraps removed.
    typedef struct packed {
        logic [1:0]       carry;
        logic [REG_W-1:0] rem;
    } rtc_fold_t;

    // Reduce a sum below 3*wrap into [0, wrap) and report the wraps taken.
    function automatic rtc_fold_t ns_fold(input logic [REG_W-1:0] sum,
                                          input logic [REG_W-1:0] wrap1,
                                          input logic [REG_W-1:0] wrap2);
        rtc_fold_t r;
        if (sum >= wrap2) begin
            r.carry = 2'd2;
            r.rem   = sum - wrap2;
        end else if (sum >= wrap1) begin
            r.carry = 2'd1;
            r.rem   = sum - wrap1;
        end else begin
            r.carry = 2'd0;
            r.rem   = sum;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_offset_regs.sv
module rtc_offset_regs
    import rtc_pkg::*;
#(
    parameter int SEC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output rtc_cmd_t         cmd,
    output logic [SEC_W-1:0] sec_ofs
);
    localparam int HI_W = SEC_W - REG_W;

    logic [OFS_NS_W-1:0] ns_ofs_q;
    logic [REG_W-1:0]    sec_lo_q;
    logic [HI_W-1:0]     sec_hi_q;

    logic hit_ns, hit_lo, hit_hi;

    always_comb begin
        hit_ns = wr_en && (rtc_addr_e'(wr_addr) == ADDR_NS_OFS);
        hit_lo = wr_en && (rtc_addr_e'(wr_addr) == ADDR_SEC_LO);
        hit_hi = wr_en && (rtc_addr_e'(wr_addr) == ADDR_SEC_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_ofs_q <= '0;
            sec_lo_q <= '0;
            sec_hi_q <= '0;
        end else begin
            if (hit_ns) ns_ofs_q <= wr_data[OFS_NS_W-1:0];
            if (hit_lo) sec_lo_q <= wr_data;
            if (hit_hi) sec_hi_q <= wr_data[HI_W-1:0];
        end
    end

    // The nanosecond write itself carries the offset into the counter.
    always_comb begin
        cmd.apply = hit_ns;
        cmd.ns    = wr_data[OFS_NS_W-1:0];
        sec_ofs   = {sec_hi_q, sec_lo_q};
    end

    always_comb begin
        unique case (rtc_addr_e'(rd_addr))
            ADDR_NS_OFS: rd_data = REG_W'(ns_ofs_q);
            ADDR_SEC_LO: rd_data = sec_lo_q;
            ADDR_SEC_HI: rd_data = REG_W'(sec_hi_q);
            default:     rd_data = '0;
        endcase
    end

    p_stage_lo_r4: assert property (@(posedge clk) disable iff (rst)
        hit_lo |=> sec_lo_q == $past(wr_data));

    p_ns_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !hit_ns |=> $stable(ns_ofs_q));

    p_spare_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rtc_addr_e'(wr_addr) == ADDR_SPARE)
        |=> $stable(sec_lo_q) && $stable(sec_hi_q) && $stable(ns_ofs_q));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int NS_INC  = 4,
    parameter int NS_WRAP = 1_000_000_000,
    parameter int SEC_W   = 48,
    localparam int NS_W   = $clog2(NS_WRAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  rtc_cmd_t         cmd,
    input  logic [SEC_W-1:0] sec_ofs,
    output logic [SEC_W-1:0] sec_q,
    output logic [NS_W-1:0]  ns_q
);
    localparam logic [REG_W-1:0] WRAP1 = REG_W'(NS_WRAP);
    localparam logic [REG_W-1:0] WRAP2 = REG_W'(2 * longint'(NS_WRAP));
    localparam logic [REG_W-1:0] INC   = REG_W'(NS_INC);

    logic [REG_W-1:0] ns_sum;
    rtc_fold_t        fold;
    logic [SEC_W-1:0] sec_add;
    logic [SEC_W-1:0] sec_d;
    logic [NS_W-1:0]  ns_d;

    always_comb begin
        ns_sum  = REG_W'(ns_q) + INC;
        sec_add = '0;
        if (cmd.apply) begin
            ns_sum  = ns_sum + REG_W'(cmd.ns);
            sec_add = sec_ofs;
        end
        fold  = ns_fold(ns_sum, WRAP1, WRAP2);
        ns_d  = fold.rem[NS_W-1:0];
        sec_d = sec_q + sec_add + SEC_W'(fold.carry);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q  <= '0;
            sec_q <= '0;
        end else begin
            ns_q  <= ns_d;
            sec_q <= sec_d;
        end
    end

    p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
        REG_W'(ns_q) < WRAP1);

    p_fold_fit_r3: assert property (@(posedge clk) disable iff (rst)
        fold.rem < WRAP1);

    p_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!cmd.apply && (REG_W'(ns_q) + INC) < WRAP1)
        |=> (REG_W'(ns_q) == REG_W'($past(ns_q)) + INC) && $stable(sec_q));

    p_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.apply && (REG_W'(ns_q) + INC) >= WRAP1)
        |=> sec_q == $past(sec_q) + SEC_W'(1));

endmodule

// File: rtl/rtc_step_counter.sv
module rtc_step_counter
    import rtc_pkg::*;
#(
    parameter int NS_INC  = 4,
    parameter int NS_WRAP = 1_000_000_000,
    parameter int SEC_W   = 48
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [1:0]                 rd_addr,
    output logic [31:0]                rd_data,
    output logic [SEC_W-1:0]           tod_sec,
    output logic [$clog2(NS_WRAP)-1:0] tod_ns
);
    rtc_cmd_t         cmd;
    logic [SEC_W-1:0] sec_ofs;

    rtc_offset_regs #(.SEC_W(SEC_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cmd     (cmd),
        .sec_ofs (sec_ofs)
    );

    rtc_time_core #(
        .NS_INC  (NS_INC),
        .NS_WRAP (NS_WRAP),
        .SEC_W   (SEC_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .sec_ofs (sec_ofs),
        .sec_q   (tod_sec),
        .ns_q    (tod_ns)
    );

endmodule

// File: tb/rtc_step_counter_bench.sv
`timescale 1ns/1ps
module rtc_step_counter_bench;

    localparam int NS_INC  = 7;
    localparam int NS_WRAP = 1000;
    localparam int SEC_W   = 40;
    localparam int NS_W    = $clog2(NS_WRAP);
    localparam longint unsigned MASK = (64'd1 << SEC_W) - 1;
    localparam longint unsigned HMSK = (64'd1 << (SEC_W - 32)) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = 2'd0;
    logic [31:0]       wr_data = 32'd0;
    logic [1:0]        rd_addr = 2'd0;
    logic [31:0]       rd_data;
    logic [SEC_W-1:0]  tod_sec;
    logic [NS_W-1:0]   tod_ns;

    always #2 clk = ~clk;

    rtc_step_counter #(
        .NS_INC  (NS_INC),
        .NS_WRAP (NS_WRAP),
        .SEC_W   (SEC_W)
    ) u_rtc_step_counter (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tod_sec (tod_sec),
        .tod_ns  (tod_ns)
    );

    typedef struct {
        longint unsigned sec;
        longint unsigned ns;
        string           tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string apply_tag = "R5";

    task automatic chk(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model: predicts the time after every clock edge.
    longint unsigned m_ns = 0, m_sec = 0, m_lo = 0, m_hi = 0;
    always @(posedge clk) begin
        exp_t            e;
        longint unsigned tot, carry, ofs;
        bit              apply, stage;
        if (rst) begin
            m_ns = 0; m_sec = 0; m_lo = 0; m_hi = 0;
        end else begin
            apply = wr_en && wr_addr == 2'd0;
            stage = wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2);
            tot   = m_ns + NS_INC + (apply ? longint'(wr_data[29:0]) : 0);
            carry = tot / NS_WRAP;
            m_ns  = tot % NS_WRAP;
            ofs   = apply ? ((m_hi << 32) | m_lo) : 0;
            m_sec = (m_sec + ofs + carry) & MASK;
            e.sec = m_sec;
            e.ns  = m_ns;
            e.tag = apply ? apply_tag : (stage ? "R4" : (carry != 0 ? "R3" : "R2"));
            sb_q.push_back(e);
            if (wr_en && wr_addr == 2'd1) m_lo = longint'(wr_data);
            if (wr_en && wr_addr == 2'd2) m_hi = longint'(wr_data) & HMSK;
        end
    end

    // Monitor: compares design outputs against the predicted items.
    always @(negedge clk) begin
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.tag, "tod_sec", longint'(tod_sec), e.sec);
            chk(e.tag, "tod_ns",  longint'(tod_ns),  e.ns);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] a,
                         input longint unsigned exp);
        rd_addr = a;
        #1;
        chk(tag, "rd_data", longint'(rd_data), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint unsigned s, ofs;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "tod_sec", longint'(tod_sec), 0);
        chk("R1", "tod_ns",  longint'(tod_ns),  0);
        rdchk("R1", 2'd0, 0);
        rdchk("R1", 2'd1, 0);
        rdchk("R1", 2'd2, 0);
        rst = 1'b0;

        // R2, R3: free running with several wraps
        idle(400);

        // R4: staging writes leave the time alone; R7 readback
        wr(2'd1, 32'd5);
        rdchk("R7", 2'd1, 5);
        wr(2'd2, 32'h0000_01FF);
        rdchk("R7", 2'd2, 32'hFF);
        wr(2'd2, 32'h0000_0012);
        rdchk("R7", 2'd2, 32'h12);
        idle(20);

        // R5: apply with a large nanosecond offset, reserved bits set
        apply_tag = "R5";
        wr(2'd0, 32'hC000_0000 | 32'd990);
        rdchk("R7", 2'd0, 990);
        idle(10);
        wr(2'd0, 32'd3);
        rdchk("R7", 2'd0, 3);
        idle(10);

        // R8: spare address
        wr(2'd3, 32'hDEAD_BEEF);
        rdchk("R8", 2'd3, 0);
        rdchk("R8", 2'd0, 3);
        rdchk("R8", 2'd1, 5);
        rdchk("R8", 2'd2, 32'h12);
        idle(5);

        // R6: step back by one second
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_00FF);
        apply_tag = "R6";
        wr(2'd0, 32'd0);
        idle(5);

        // R3: drive seconds to all ones, then let a wrap roll them to zero
        while (tod_ns >= NS_W'(50)) @(negedge clk);
        s   = longint'(tod_sec);
        ofs = (MASK - s) & MASK;
        wr(2'd1, ofs[31:0]);
        wr(2'd2, ofs[63:32]);
        apply_tag = "R3";
        wr(2'd0, 32'd0);
        #1;
        chk("R3", "tod_sec at max", longint'(tod_sec), MASK);
        idle(200);
        chk("R3", "tod_sec rolled", longint'(tod_sec), 0);

        idle(3);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule